// File: doc/BRIEF.md
# Network Power-State Gating Controller

This block sits between the power-management configuration logic of a network controller and its datapaths. It takes the requested device power state (D0 to D3) and gates the receive path, the interrupt status updates, the transmit path and bus-master DMA. In any low-power state, both FIFOs are frozen with their contents kept rather than flushed. A requested state is adopted only when no receive frame is in progress, so a frame is never left partly written.

While the device is in a low-power state, wake events from external detectors arrive as single-cycle pulses. There are three kinds: magic packet, wakeup frame match and link re-established. A per-event mask selects which of them latch into a status vector. Any latched bit drives the active-low power-management event output. Software clears status bits with a write-one-to-clear pulse.

On return to D0, the block resumes in a fixed order. The transmit enable comes back first. If a transmission was cut short by the power-down, a one-cycle retransmit request follows. Bus-master DMA is re-enabled last, so that pending data is moved into the transmit FIFO only after the retransmit has been requested.

Top module: `pwr_gate_ctl`

## Requirements
- R1: After reset the applied state is D0. `rx_en_o`, `isr_upd_en_o`, `tx_en_o` and `dma_en_o` are high, `fifo_hold_o` and `retx_req_o` are low, `pme_n_o` is high and `pme_stat_o` is zero.
- R2: The requested state `pwr_req_i` (0=D0, 1=D1, 2=D2, 3=D3) is adopted at a clock edge where `rx_frame_busy_i` is low. While `rx_frame_busy_i` is high, the applied state does not change.
- R3: From the edge that adopts D1, D2 or D3, `rx_en_o` and `isr_upd_en_o` are low and `fifo_hold_o` is high. From the edge that adopts D0, these three outputs return to their D0 values.
- R4: From the edge that adopts a low-power state, `tx_en_o`, `dma_en_o` and `retx_req_o` are low.
- R5: In a low-power state, a pulse on `wake_i[i]` with `wake_mask_i[i]` high sets `pme_stat_o[i]` at that edge. The bit positions are 0 for magic packet, 1 for wakeup frame and 2 for link re-established. `pme_n_o` is low exactly while any status bit is set.
- R6: A wake pulse whose mask bit is low, or one that arrives while the applied state is D0, leaves `pme_stat_o` unchanged.
- R7: A high bit in `pme_clr_i` clears the matching status bit at the edge. If a qualified wake pulse for the same bit arrives in the same cycle, the set wins.
- R8: At the edge that adopts D0, all status bits are cleared if `pme_en_i` is low. If `pme_en_i` is high, the status bits are kept.
- R9: If D0 is adopted at edge k, then `tx_en_o` rises at edge k+1 and `dma_en_o` rises at edge k+3.
- R10: `retx_req_o` is a one-cycle pulse at edge k+2, which is one cycle after `tx_en_o` rises. It is issued only if `tx_pkt_partial_i` was high at the first edge after the low-power state was adopted.
- R11: If a low-power state is adopted again before the retransmit pulse is issued, the pending retransmit is kept. It is issued on the next return to D0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_req_i | input | 2 | Requested power state, 0=D0 to 3=D3 |
| rx_frame_busy_i | input | 1 | A receive frame is in progress |
| wake_i | input | 3 | Wake pulses: bit0 magic, bit1 frame match, bit2 link up |
| wake_mask_i | input | 3 | Per-event wake enable |
| pme_en_i | input | 1 | Power-management event enable |
| pme_clr_i | input | 3 | Write-one-to-clear pulse for the status bits |
| tx_pkt_partial_i | input | 1 | A transmit packet is partly sent |
| rx_en_o | output | 1 | Receive state machine and FIFO write enable |
| isr_upd_en_o | output | 1 | Interrupt status update enable |
| fifo_hold_o | output | 1 | Freeze both FIFOs with their contents kept |
| tx_en_o | output | 1 | Transmit enable |
| dma_en_o | output | 1 | Bus-master DMA enable |
| retx_req_o | output | 1 | Retransmit request pulse |
| pme_stat_o | output | 3 | Latched wake status |
| pme_n_o | output | 1 | Power-management event, active low |

## Verification
The hardest case to reach from the ports is the interrupted resume. A pending retransmit must survive a second power-down that lands between the rise of the transmit enable and the retransmit pulse. The stimulus marks a partial packet on power-down and returns to D0. It then requests D3 again exactly one edge after adoption, while the sequencer is in its transmit-only step, and checks that the pulse appears on the following resume. A second hard case is the set/clear collision: the bench pulses a wake event and its clear bit in the same cycle. A sweep then covers every low-power state, every mask value and every event.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
    localparam int unsigned PS_W   = 2;
    localparam int unsigned N_WAKE = 3;

    typedef enum logic [PS_W-1:0] {
        PS_D0 = 2'd0,
        PS_D1 = 2'd1,
        PS_D2 = 2'd2,
        PS_D3 = 2'd3
    } pwr_state_e;

    typedef enum logic [1:0] {
        RS_RUN  = 2'd0,
        RS_LOW  = 2'd1,
        RS_TXUP = 2'd2,
        RS_RETX = 2'd3
    } resume_e;
endpackage

// File: rtl/pgc_state_apply.sv
module pgc_state_apply
    import pgc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PS_W-1:0] req_i,
    input  logic            busy_i,
    output logic            low_o,
    output logic            d0_entry_o
);
    typedef struct packed {
        pwr_state_e st;
    } apply_t;

    apply_t q, d;

    always_comb begin
        d = q;
        if (!busy_i) begin
            d.st = pwr_state_e'(req_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st <= PS_D0;
        end else begin
            q <= d;
        end
    end

    assign low_o      = (q.st != PS_D0);
    assign d0_entry_o = low_o && !busy_i && (pwr_state_e'(req_i) == PS_D0);

    // R2: a frame in progress pins the applied state
    p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(q.st));
endmodule

// File: rtl/pgc_wake_pme.sv
module pgc_wake_pme
    import pgc_pkg::*;
#(
    parameter int unsigned NW = N_WAKE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          low_i,
    input  logic          d0_entry_i,
    input  logic          pme_en_i,
    input  logic [NW-1:0] wake_i,
    input  logic [NW-1:0] mask_i,
    input  logic [NW-1:0] clr_i,
    output logic [NW-1:0] stat_o,
    output logic          pme_n_o
);
    typedef struct packed {
        logic [NW-1:0] pend;
    } pme_t;

    pme_t q, d;
    logic [NW-1:0] set_vec;

    for (genvar i = 0; i < NW; i++) begin : g_evt
        assign set_vec[i] = wake_i[i] && mask_i[i] && low_i;
    end

    always_comb begin
        d = q;
        d.pend = (q.pend & ~clr_i) | set_vec;
        if (d0_entry_i && !pme_en_i) begin
            d.pend = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.pend <= '0;
        end else begin
            q <= d;
        end
    end

    assign stat_o  = q.pend;
    assign pme_n_o = ~(|q.pend);

    // R6: no status bit appears while at full power
    p_d0_nowake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !low_i |=> ((q.pend & ~$past(q.pend)) == '0));

    // R7: a clear without a competing set drops the bit
    p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q.pend & $past(clr_i & ~set_vec)) == '0));
endmodule

// File: rtl/pgc_resume_seq.sv
module pgc_resume_seq
    import pgc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic low_i,
    input  logic partial_i,
    output logic tx_en_o,
    output logic dma_en_o,
    output logic retx_o
);
    typedef struct packed {
        resume_e seq;
        logic    part;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        unique case (q.seq)
            RS_RUN, RS_TXUP: begin
                if (low_i) begin
                    d.seq  = RS_LOW;
                    d.part = q.part | partial_i;
                end else if (q.seq == RS_TXUP) begin
                    d.seq = RS_RETX;
                end
            end
            RS_RETX: begin
                if (low_i) begin
                    d.seq = RS_LOW;
                end else begin
                    d.seq  = RS_RUN;
                    d.part = 1'b0;
                end
            end
            RS_LOW: begin
                if (!low_i) begin
                    d.seq = RS_TXUP;
                end
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.seq  <= RS_RUN;
            q.part <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign tx_en_o  = !low_i && (q.seq != RS_LOW);
    assign dma_en_o = !low_i && (q.seq == RS_RUN);
    assign retx_o   = !low_i && (q.seq == RS_RETX) && q.part;

    // R10: the retransmit request lasts a single cycle
    p_retx_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        retx_o |=> !retx_o);

    // R9: retransmit only after transmit has been up for a cycle
    p_retx_after_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        retx_o |-> (tx_en_o && $past(tx_en_o)));

    // R9: DMA never comes back ahead of transmit
    p_dma_after_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_en_o) |-> $past(tx_en_o));
endmodule

// File: rtl/pwr_gate_ctl.sv
module pwr_gate_ctl
    import pgc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PS_W-1:0]     pwr_req_i,
    input  logic                rx_frame_busy_i,
    input  logic [N_WAKE-1:0]   wake_i,
    input  logic [N_WAKE-1:0]   wake_mask_i,
    input  logic                pme_en_i,
    input  logic [N_WAKE-1:0]   pme_clr_i,
    input  logic                tx_pkt_partial_i,
    output logic                rx_en_o,
    output logic                isr_upd_en_o,
    output logic                fifo_hold_o,
    output logic                tx_en_o,
    output logic                dma_en_o,
    output logic                retx_req_o,
    output logic [N_WAKE-1:0]   pme_stat_o,
    output logic                pme_n_o
);
    logic low;
    logic d0_entry;

    pgc_state_apply u_apply (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (pwr_req_i),
        .busy_i     (rx_frame_busy_i),
        .low_o      (low),
        .d0_entry_o (d0_entry)
    );

    pgc_wake_pme #(.NW(N_WAKE)) u_pme (
        .clk        (clk),
        .rst_n      (rst_n),
        .low_i      (low),
        .d0_entry_i (d0_entry),
        .pme_en_i   (pme_en_i),
        .wake_i     (wake_i),
        .mask_i     (wake_mask_i),
        .clr_i      (pme_clr_i),
        .stat_o     (pme_stat_o),
        .pme_n_o    (pme_n_o)
    );

    pgc_resume_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .low_i     (low),
        .partial_i (tx_pkt_partial_i),
        .tx_en_o   (tx_en_o),
        .dma_en_o  (dma_en_o),
        .retx_o    (retx_req_o)
    );

    assign rx_en_o      = !low;
    assign isr_upd_en_o = !low;
    assign fifo_hold_o  = low;

    // R4: a frozen datapath never transmits, moves data or retransmits
    p_tx_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_hold_o |-> (!tx_en_o && !dma_en_o && !retx_req_o));
endmodule

// File: tb/sim_pwr_gate_ctl.sv
module sim_pwr_gate_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwr_req = 2'd0;
    logic       busy = 1'b0;
    logic [2:0] wake = 3'd0;
    logic [2:0] mask = 3'd7;
    logic       pme_en = 1'b1;
    logic [2:0] clr = 3'd0;
    logic       partial = 1'b0;
    logic       rx_en, isr_en, hold, tx_en, dma_en, retx, pme_n;
    logic [2:0] stat;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    pwr_gate_ctl u0 (
        .clk(clk), .rst_n(rst_n), .pwr_req_i(pwr_req), .rx_frame_busy_i(busy),
        .wake_i(wake), .wake_mask_i(mask), .pme_en_i(pme_en), .pme_clr_i(clr),
        .tx_pkt_partial_i(partial), .rx_en_o(rx_en), .isr_upd_en_o(isr_en),
        .fifo_hold_o(hold), .tx_en_o(tx_en), .dma_en_o(dma_en),
        .retx_req_o(retx), .pme_stat_o(stat), .pme_n_o(pme_n)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // packs {rx_en,isr,hold,tx_en,dma,retx}
    function automatic int gates();
        return {26'd0, rx_en, isr_en, hold, tx_en, dma_en, retx};
    endfunction

    // return to D0 and walk the resume sequence; exp_retx expected at k+2
    task automatic resume(input logic exp_retx);
        pwr_req = 2'd0;
        step();
        chk("R3 d0 rx", {rx_en, isr_en, hold}, 3'b110);
        chk("R9 tx still off at k", tx_en, 0);
        step();
        chk("R9 tx up at k+1", {tx_en, dma_en, retx}, 3'b100);
        step();
        chk("R10 retx at k+2", {tx_en, dma_en, retx}, {2'b10, exp_retx});
        step();
        chk("R9 dma up at k+3", {tx_en, dma_en, retx}, 3'b110);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step();
        step();
        // R1 reset state
        chk("R1 gates", gates(), 6'b110110);
        chk("R1 pme_n", pme_n, 1);
        chk("R1 stat", stat, 0);
        rst_n = 1'b1;
        step();
        chk("R1 gates after release", gates(), 6'b110110);

        // R6: wake in D0 ignored
        for (int e = 0; e < 3; e++) begin
            wake = 3'(1 << e);
            step();
            wake = 3'd0;
            chk("R6 d0 wake", stat, 0);
        end

        // R2: busy holds state
        busy = 1'b1;
        pwr_req = 2'd2;
        step();
        step();
        chk("R2 held while busy", rx_en, 1);
        busy = 1'b0;
        step();
        chk("R2 adopted after busy", rx_en, 0);
        resume(1'b0);

        // sweep: every low state, mask and event
        for (int s = 1; s < 4; s++) begin
            for (int m = 0; m < 8; m++) begin
                for (int e = 0; e < 3; e++) begin
                    int exp_stat;
                    pwr_req = 2'(s);
                    step();
                    chk("R3 low gates", {rx_en, isr_en, hold}, 3'b001);
                    chk("R4 low tx", {tx_en, dma_en, retx}, 0);
                    mask = 3'(m);
                    wake = 3'(1 << e);
                    step();
                    wake = 3'd0;
                    exp_stat = ((m >> e) & 1) << e;
                    chk("R5 R6 stat", stat, exp_stat);
                    chk("R5 pme_n", pme_n, (exp_stat != 0) ? 0 : 1);
                    clr = 3'd7;
                    step();
                    clr = 3'd0;
                    chk("R7 cleared", stat, 0);
                    resume(1'b0);
                end
            end
        end
        mask = 3'd7;

        // R7: set beats clear in the same cycle; other bit clears
        pwr_req = 2'd1;
        step();
        wake = 3'b100;
        step();
        wake = 3'b001;
        clr = 3'b101;
        step();
        wake = 3'd0;
        clr = 3'd0;
        chk("R7 set wins", stat, 3'b001);

        // R8: kept with pme_en high
        pme_en = 1'b1;
        resume(1'b0);
        chk("R8 kept", stat, 3'b001);
        chk("R5 pme_n held", pme_n, 0);
        clr = 3'd7;
        step();
        clr = 3'd0;

        // R8: cleared with pme_en low at the adoption edge
        pwr_req = 2'd3;
        step();
        wake = 3'b010;
        step();
        wake = 3'd0;
        pme_en = 1'b0;
        pwr_req = 2'd0;
        step();
        chk("R8 cleared at entry", stat, 0);
        chk("R8 pme_n released", pme_n, 1);
        step();
        step();
        step();
        pme_en = 1'b1;

        // R10: partial packet -> retransmit
        pwr_req = 2'd1;
        partial = 1'b1;
        step();
        step();
        partial = 1'b0;
        resume(1'b1);
        step();
        chk("R10 single pulse", retx, 0);

        // R10: partial raised only later in low power -> no retransmit
        pwr_req = 2'd2;
        step();
        step();
        partial = 1'b1;
        step();
        partial = 1'b0;
        resume(1'b0);

        // R11: re-entry during transmit-only step keeps the request
        pwr_req = 2'd2;
        partial = 1'b1;
        step();
        step();
        partial = 1'b0;
        pwr_req = 2'd0;
        step();
        step();
        chk("R11 tx up", tx_en, 1);
        pwr_req = 2'd3;
        step();
        chk("R11 low again", {tx_en, retx, hold}, 3'b001);
        step();
        resume(1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule